// File: doc/BRIEF.md
# Stretchable Two-Phase CPU Bus Clock Generator

This block derives the phase-0 clock of an 8-bit microprocessor bus from a much faster system clock. The clock is intentionally lopsided. The low phase is short, and its length is a programmed number of system cycles. That count is clamped so the low phase can never exceed the 5 µs ceiling that the processor tolerates. The high phase has no fixed length. When the clock rises, the processor drives address and read/write. One system cycle later the block raises a single-cycle start strobe, so the memory or I/O responder has a registered point at which to sample them. The responder may then take as long as it needs. When it raises `done_i`, the clock falls, and that falling edge completes the data transfer.

There are two operating modes. In free-running mode (`step_en_i` low), the falling edge follows `done_i` directly. In single-step mode (`step_en_i` high), the clock stays high after `done_i` until a `step_i` pulse arrives. This is safe because only the low phase has a time limit. Reset holds the clock low. After reset is released, the clock runs one programmed low phase and then starts cycling normally.

Top module: `clk2ph_gen`

## Requirements
- R1: While `rst_ni` is low, `phi0_o` and `cyc_start_o` are 0. After release, `phi0_o` stays low for exactly the programmed low length (counting the cycle in which reset is released) and then rises.
- R2: Each low phase of `phi0_o` lasts exactly `low_cycles_i` system cycles. A value of 0 is treated as 1.
- R3: The low length is clamped to MAX_LOW_CYC = SYS_CLK_MHZ*MAX_LOW_NS/1000 cycles (80 with the defaults of 16 MHz and 5000 ns). Any larger request yields exactly MAX_LOW_CYC.
- R4: `cyc_start_o` is high for exactly one system cycle per clock period. That cycle is the second system cycle of the high phase, one cycle after the rising edge.
- R5: `done_i` is ignored in the first high cycle, before `cyc_start_o` has been shown. While `done_i` (and `step_i`) stay low, `phi0_o` stays high indefinitely.
- R6: In free-running mode, when `done_i` is sampled high at a clock edge during or after the `cyc_start_o` cycle, `phi0_o` is low after that same edge. The high phase therefore lasts 2 + d system cycles, where d is the number of cycles `done_i` is withheld after `cyc_start_o`.
- R7: In single-step mode, after `done_i` is accepted, `phi0_o` stays high until `step_i` is sampled high. It then falls at that edge, and the normal programmed low phase follows.
- R8: `step_i` has no effect during the low phase or before `done_i` has been accepted. The low length and the high level are unchanged.
- R9: No low phase of `phi0_o` ever exceeds MAX_LOW_CYC system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| low_cycles_i | input | LOW_W | Requested low-phase length in system cycles |
| step_en_i | input | 1 | 1 selects single-step mode, 0 selects free-running |
| step_i | input | 1 | Step request; releases a held high phase |
| done_i | input | 1 | Responder finished the current access |
| phi0_o | output | 1 | Phase-0 clock to the processor |
| cyc_start_o | output | 1 | One-cycle strobe one cycle after each rising edge |

## Verification
On every cycle, the bound checker enforces the bound on low-phase duration and the placement and width of the start strobe relative to the rising edge. It also enforces that the clock never falls without a done or step request, and that the high phase never ends in its first cycle. The exact low-phase length for each programmed value, including the zero case and the clamp, and the exact high-phase length as a function of the responder's delay, are visible only in the bench's scenarios. The same holds for the single-step hold and release, the stray step pulses, and the early done pulse that must be ignored.

// File: rtl/clk2ph_pkg.sv
package clk2ph_pkg;

   typedef enum logic [1:0] {
      PH_LOW  = 2'd0,
      PH_HIGH = 2'd1,
      PH_HOLD = 2'd2
   } ph_state_t;

endpackage

// File: rtl/clk2ph_low_limit.sv
module clk2ph_low_limit #(
   parameter int LOW_W   = 8,
   parameter int MAX_LOW = 80,
   localparam int CNT_W  = $clog2(MAX_LOW + 1)
) (
   input  logic [LOW_W-1:0] req_i,
   output logic [CNT_W-1:0] lim_o
);

   localparam int REQ_MAX = (1 << LOW_W) - 1;

   generate
      if (REQ_MAX > MAX_LOW) begin : g_clamp
         // request range can exceed the ceiling: saturate
         always_comb begin
            if (req_i == '0)
               lim_o = CNT_W'(1);
            else if (req_i > LOW_W'(MAX_LOW))
               lim_o = CNT_W'(MAX_LOW);
            else
               lim_o = CNT_W'(req_i);
         end
      end else begin : g_pass
         // every request already fits under the ceiling
         always_comb begin
            if (req_i == '0)
               lim_o = CNT_W'(1);
            else
               lim_o = CNT_W'(req_i);
         end
      end
   endgenerate

endmodule

// File: rtl/clk2ph_low_timer.sv
module clk2ph_low_timer #(
   parameter int MAX_LOW = 80,
   localparam int CNT_W  = $clog2(MAX_LOW + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] lim_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_next;

   assign cnt_next = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign expire_o = run_i && (cnt_next == {1'b0, lim_i});

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (!run_i || expire_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_next[CNT_W-1:0];
   end

endmodule

// File: rtl/clk2ph_phase_fsm.sv
module clk2ph_phase_fsm
   import clk2ph_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic low_expire_i,
   input  logic step_en_i,
   input  logic step_i,
   input  logic done_i,
   output logic in_low_o,
   output logic phi0_o,
   output logic cyc_start_o
);

   ph_state_t state_q;
   logic      phi0_q;
   logic      start_q;
   logic      fresh_q;
   logic      armed_q;
   logic      accept;

   // done counts only once the start strobe has been shown
   assign accept   = done_i && (start_q || armed_q);
   assign in_low_o = (state_q == PH_LOW);
   assign phi0_o   = phi0_q;
   assign cyc_start_o = start_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= PH_LOW;
         phi0_q  <= 1'b0;
         start_q <= 1'b0;
         fresh_q <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (state_q)
            PH_LOW: begin
               armed_q <= 1'b0;
               if (low_expire_i) begin
                  state_q <= PH_HIGH;
                  phi0_q  <= 1'b1;
                  fresh_q <= 1'b1;
               end
            end
            PH_HIGH: begin
               if (fresh_q) begin
                  start_q <= 1'b1;
                  fresh_q <= 1'b0;
               end
               armed_q <= armed_q | start_q;
               if (accept) begin
                  if (step_en_i) begin
                     state_q <= PH_HOLD;
                  end else begin
                     state_q <= PH_LOW;
                     phi0_q  <= 1'b0;
                  end
               end
            end
            PH_HOLD: begin
               if (step_i) begin
                  state_q <= PH_LOW;
                  phi0_q  <= 1'b0;
               end
            end
            default: begin
               state_q <= PH_LOW;
               phi0_q  <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/clk2ph_gen.sv
module clk2ph_gen #(
   parameter int SYS_CLK_MHZ = 16,
   parameter int MAX_LOW_NS  = 5000,
   parameter int LOW_W       = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LOW_W-1:0] low_cycles_i,
   input  logic             step_en_i,
   input  logic             step_i,
   input  logic             done_i,
   output logic             phi0_o,
   output logic             cyc_start_o
);

   localparam int MAX_LOW_CYC = (SYS_CLK_MHZ * MAX_LOW_NS) / 1000;
   localparam int CNT_W       = $clog2(MAX_LOW_CYC + 1);

   generate
      if (SYS_CLK_MHZ < 1) begin : g_bad_clk
         $error("SYS_CLK_MHZ must be at least 1");
      end
      if (LOW_W < 1 || LOW_W > 30) begin : g_bad_w
         $error("LOW_W must be within 1..30");
      end
      if (MAX_LOW_CYC < 1) begin : g_bad_lim
         $error("low-phase ceiling must allow at least one cycle");
      end
   endgenerate

   logic [CNT_W-1:0] low_lim;
   logic             low_expire;
   logic             in_low;

   clk2ph_low_limit #(
      .LOW_W   (LOW_W),
      .MAX_LOW (MAX_LOW_CYC)
   ) u_limit (
      .req_i (low_cycles_i),
      .lim_o (low_lim)
   );

   clk2ph_low_timer #(
      .MAX_LOW (MAX_LOW_CYC)
   ) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (in_low),
      .lim_i    (low_lim),
      .expire_o (low_expire)
   );

   clk2ph_phase_fsm u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .low_expire_i (low_expire),
      .step_en_i    (step_en_i),
      .step_i       (step_i),
      .done_i       (done_i),
      .in_low_o     (in_low),
      .phi0_o       (phi0_o),
      .cyc_start_o  (cyc_start_o)
   );

endmodule

// File: rtl/clk2ph_checker.sv
module clk2ph_checker #(
   parameter int MAX_LOW = 80
) (
   input logic clk_i,
   input logic rst_ni,
   input logic phi0_o,
   input logic cyc_start_o,
   input logic done_i,
   input logic step_i
);

   int low_run_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         low_run_q <= 0;
      else if (!phi0_o)
         low_run_q <= low_run_q + 1;
      else
         low_run_q <= 0;
   end

   assert_low_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_run_q <= MAX_LOW);

   assert_start_after_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phi0_o) |=> cyc_start_o);

   assert_start_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cyc_start_o |=> !cyc_start_o);

   assert_start_in_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cyc_start_o |-> (phi0_o && $past(phi0_o)));

   assert_hold_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phi0_o && !done_i && !step_i) |=> phi0_o);

   assert_no_early_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phi0_o) |=> phi0_o);

endmodule

bind clk2ph_gen clk2ph_checker #(.MAX_LOW(MAX_LOW_CYC)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .phi0_o      (phi0_o),
   .cyc_start_o (cyc_start_o),
   .done_i      (done_i),
   .step_i      (step_i)
);

// File: tb/clk2ph_gen_tb_top.sv
`timescale 1ns/1ps
module clk2ph_gen_tb_top;

   localparam int LOW_W = 8;
   localparam int CEIL  = 80;
   localparam int NVEC  = 8;
   localparam int V_LOW [NVEC] = '{1, 4, 8, 0, 80, 200, 255, 3};
   localparam int V_DLY [NVEC] = '{0, 3, 0, 1, 2, 0, 5, 10};
   localparam int V_EXP [NVEC] = '{1, 4, 8, 1, 80, 80, 80, 3};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [LOW_W-1:0] low_cycles = '0;
   logic             step_en = 1'b0;
   logic             step = 1'b0;
   logic             done = 1'b0;
   logic             phi0;
   logic             cyc_start;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   clk2ph_gen dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .low_cycles_i (low_cycles),
      .step_en_i    (step_en),
      .step_i       (step),
      .done_i       (done),
      .phi0_o       (phi0),
      .cyc_start_o  (cyc_start)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // counts low samples starting at the current negedge
   task automatic count_low(output int n);
      n = 0;
      while (phi0 == 1'b0 && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // one full period: low phase then high phase with done after dly
   task automatic run_period(input int low, input int dly,
                             output int lo_n, output int hi_n, output int cs_n);
      int after;
      bit seen;
      low_cycles = LOW_W'(low);
      count_low(lo_n);
      hi_n = 0; cs_n = 0; after = 0; seen = 0;
      while (phi0 == 1'b1 && hi_n < 1000) begin
         hi_n++;
         if (cyc_start) begin cs_n++; seen = 1; end
         if (seen) begin
            if (after == dly) done = 1'b1;
            after++;
         end
         @(negedge clk);
      end
      done = 1'b0;
   endtask

   initial begin
      int lo, hi, cs, n;
      bit stay;
      // R1: reset state
      low_cycles = 8'd5;
      repeat (4) @(negedge clk);
      check(phi0 == 1'b0 && cyc_start == 1'b0, "R1", {phi0, cyc_start}, 0);
      rst_n = 1'b1;
      run_period(5, 0, lo, hi, cs);
      check(lo == 5, "R1", lo, 5);
      check(hi == 2, "R6", hi, 2);

      // vector table: R2, R3, R4, R6
      for (int i = 0; i < NVEC; i++) begin
         run_period(V_LOW[i], V_DLY[i], lo, hi, cs);
         check(lo == V_EXP[i], (V_LOW[i] > CEIL) ? "R3" : "R2", lo, V_EXP[i]);
         check(hi == 2 + V_DLY[i], "R6", hi, 2 + V_DLY[i]);
         check(cs == 1, "R4", cs, 1);
      end

      // R5: done pulse in the first high cycle is ignored, high holds
      low_cycles = 8'd4;
      count_low(lo);
      done = 1'b1;          // first high cycle
      @(negedge clk);
      check(cyc_start == 1'b1, "R4", cyc_start, 1);
      done = 1'b0;
      stay = 1;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (phi0 != 1'b1 || cyc_start != 1'b0) stay = 0;
      end
      check(stay, "R5", stay, 1);
      done = 1'b1;
      @(negedge clk);
      check(phi0 == 1'b0, "R6", phi0, 0);
      done = 1'b0;

      // R8: step pulse during low phase leaves the low length unchanged
      low_cycles = 8'd6;
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      count_low(n);
      check(n + 1 == 6, "R8", n + 1, 6);

      // single-step mode: step before done is ignored (R8)
      step_en = 1'b1;
      step = 1'b1;           // first high cycle
      @(negedge clk);
      step = 1'b0;
      check(phi0 == 1'b1 && cyc_start == 1'b1, "R8", phi0, 1);
      @(negedge clk);
      check(phi0 == 1'b1, "R8", phi0, 1);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      // R7: held high until step
      stay = (phi0 == 1'b1);
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (phi0 != 1'b1) stay = 0;
      end
      check(stay, "R7", stay, 1);
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      check(phi0 == 1'b0, "R7", phi0, 0);
      count_low(n);
      check(n == 6, "R7", n, 6);

      // back to free-running: R6 after mode change
      step_en = 1'b0;
      run_period(2, 1, lo, hi, cs);
      check(hi == 3, "R6", hi, 3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule